// File: doc/BRIEF.md
# PCI Type-0 Configuration Header with Expansion ROM Decode

This block is the configuration register file of one PCI function, together with the decoder for its expansion ROM. A configuration agent reaches it through a 32-bit port. The agent gives a dword index, byte enables and a write flag. A read returns its data in a register on the cycle after the request.

The header reports a fixed identity, a latency/header-type/BIST word, a subsystem word and a capabilities pointer of zero. Six dwords of base-address storage take byte-enabled writes. The expansion ROM base register takes writes under the byte enables and then masks the merged value. The mask aligns the base to the ROM size, with a floor of 2 KB, and keeps bit 0 as the enable.

The memory port serves reads from the ROM while it is enabled. The window starts at the programmed base plus a fixed memory offset. Its end is clipped to an upper memory limit. The ROM contents are generated from a closed-form byte function of the offset, so no memory array is stored.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After reset, the expansion ROM base register reads 0, the ROM is disabled, and cfg_rdata_o, mem_hit_o and mem_rdata_o are 0.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {CLASS_CODE, REVISION}. Dword 3 reads BIST in bits 31:24, header type in bits 23:16, latency timer in bits 15:8 and 0 in bits 7:0. Writes to dwords 0, 2 and 3 leave their read values unchanged.
- R3: Dword 11 (byte offset 0x2C) reads the subsystem ID in bits 31:16 and the subsystem vendor ID in bits 15:0. Writes to it have no effect.
- R4: Dword 13 (0x34), the capabilities pointer, reads 0. Every dword not listed in R2, R3, R5 and R6 reads 0. Writes to any of these dwords have no effect.
- R5: Dwords 4 to 9 (0x10 to 0x24) are plain storage. A write updates only the bytes whose enable bit is set, and enable bit n covers data bits 8n+7:8n.
- R6: Dword 12 (0x30) is the expansion ROM base register. A write first merges the data into the register under the byte enables. The merged value is then ANDed with 0xFFFFF801 and with ~(ROM_BYTES-1)|1. As a result, bit 0 holds the enable, bits 10:1 read 0, and the base is aligned to the larger of 2 KB and ROM_BYTES.
- R7: With ROM_BYTES = 0, the expansion ROM base register reads 0 after every write.
- R8: A configuration read returns its data on cfg_rdata_o in the cycle after the request and holds it until the next read. A write is seen by any read issued in a later cycle.
- R9: A memory read is claimed only while bit 0 of the ROM base register is set. The window runs from S = (base with bit 0 cleared) + MEM_OFFSET to S + ROM_BYTES - 1.
- R10: The end of the window is clamped to MEM_LIMIT, so no address above MEM_LIMIT is claimed.
- R11: Memory writes are never claimed, including writes inside the window.
- R12: mem_hit_o and mem_rdata_o are registered one cycle after the request, and mem_rdata_o is 0 on a miss. On a hit, with offset o = addr - S rounded down to a multiple of 4, the data is the little-endian dword made of bytes o..o+3. Byte k of the ROM is k[7:0] ^ k[15:8] ^ k[23:16] ^ k[31:24] ^ 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration access request |
| cfg_we_i | input | 1 | Configuration write when 1, read when 0 |
| cfg_dw_i | input | 6 | Dword index into the 256-byte header |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Registered configuration read data |
| mem_req_i | input | 1 | Memory-space access request |
| mem_we_i | input | 1 | Memory-space write when 1 |
| mem_addr_i | input | 32 | Memory-space byte address |
| mem_hit_o | output | 1 | ROM claimed the previous request |
| mem_rdata_o | output | 32 | ROM read data, 0 on miss |

## Verification
The assertions assume that the inputs carry no X or Z after reset and that mem_we_i is meaningful only while mem_req_i is high. They also assume that ROM_BYTES is zero or a power of two, because the alignment check is only correct for such sizes. The bench drives every input on the falling clock edge and returns requests to idle between accesses. It uses only ROM sizes of 0, 512 and 4096 bytes. The ROM windows it programs keep S + ROM_BYTES below 2^32, so the decoder's 33-bit window arithmetic stays inside the case the assertions describe.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam logic [5:0] DW_ID      = 6'h00;
  localparam logic [5:0] DW_CLASS   = 6'h02;
  localparam logic [5:0] DW_MISC    = 6'h03;
  localparam logic [5:0] DW_BAR0    = 6'h04;
  localparam int unsigned NUM_BARS  = 6;
  localparam logic [5:0] DW_SUBSYS  = 6'h0B;
  localparam logic [5:0] DW_ROMBAR  = 6'h0C;
  localparam logic [5:0] DW_CAP     = 6'h0D;

  typedef struct packed {
    logic        req;
    logic        we;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_cmd_t;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [7:0] rom_byte(input logic [31:0] k);
    return k[7:0] ^ k[15:8] ^ k[23:16] ^ k[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] rom_dword(input logic [31:0] base);
    return {rom_byte(base + 32'd3), rom_byte(base + 32'd2),
            rom_byte(base + 32'd1), rom_byte(base)};
  endfunction
endpackage

// File: rtl/pci_cfg_bar_store.sv
module pci_cfg_bar_store
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NUM = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM-1:0]        sel_i,
  input  logic                  wr_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  output logic [NUM-1:0][31:0]  bars_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_bar
    logic [31:0] bar_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                bar_q <= '0;
      else if (wr_i && sel_i[g])  bar_q <= be_merge(bar_q, wdata_i, be_i);
    end
    assign bars_o[g] = bar_q;
  end
endmodule

// File: rtl/pci_cfg_rom_bar.sv
module pci_cfg_rom_bar
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] bar_o
);
  localparam logic [31:0] SIZE_M1 = (ROM_BYTES == 0) ? 32'd0 : 32'(ROM_BYTES) - 32'd1;
  // enable bit kept, 2 KB floor, aligned to size
  localparam logic [31:0] KEEP    = (ROM_BYTES == 0) ? 32'd0
                                  : (32'hFFFF_F801 & (~SIZE_M1 | 32'd1));

  logic [31:0] bar_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bar_q <= '0;
    else if (wr_i) bar_q <= be_merge(bar_q, wdata_i, be_i) & KEEP;
  end
  assign bar_o = bar_q;
endmodule

// File: rtl/pci_cfg_rom_decode.sv
module pci_cfg_rom_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ROM_BYTES  = 4096,
  parameter logic [31:0] MEM_OFFSET = 32'h4000_0000,
  parameter logic [31:0] MEM_LIMIT  = 32'hC000_07FF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] bar_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [31:0] rdata_o
);
  if (ROM_BYTES == 0) begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, bar_i, req_i, we_i, addr_i};
    assign hit_o   = 1'b0;
    assign rdata_o = '0;
  end else begin : g_rom
    logic [32:0] start_w, end_raw, end_w, addr_w;
    logic [31:0] off_w;
    logic        claim;
    logic        hit_q;
    logic [31:0] data_q;

    assign addr_w  = {1'b0, addr_i};
    assign start_w = {1'b0, bar_i[31:1], 1'b0} + {1'b0, MEM_OFFSET};
    assign end_raw = start_w + 33'(ROM_BYTES) - 33'd1;
    assign end_w   = (end_raw > {1'b0, MEM_LIMIT}) ? {1'b0, MEM_LIMIT} : end_raw;
    assign claim   = req_i && !we_i && bar_i[0] && (addr_w >= start_w) && (addr_w <= end_w);
    assign off_w   = (addr_i - start_w[31:0]) & ~32'd3;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q  <= 1'b0;
        data_q <= '0;
      end else begin
        hit_q  <= claim;
        data_q <= claim ? rom_dword(off_w) : 32'd0;
      end
    end
    assign hit_o   = hit_q;
    assign rdata_o = data_q;
  end
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1AB7,
  parameter logic [15:0] DEVICE_ID  = 16'h0C3F,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h030000,
  parameter logic [7:0]  LAT_TIMER  = 8'h20,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  BIST       = 8'h05,
  parameter logic [15:0] SUBVEN_ID  = 16'h2B11,
  parameter logic [15:0] SUBSYS_ID  = 16'h7E02,
  parameter int unsigned ROM_BYTES  = 4096,
  parameter logic [31:0] MEM_OFFSET = 32'h4000_0000,
  parameter logic [31:0] MEM_LIMIT  = 32'hC000_07FF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_req_i,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_dw_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        mem_req_i,
  input  logic        mem_we_i,
  input  logic [31:0] mem_addr_i,
  output logic        mem_hit_o,
  output logic [31:0] mem_rdata_o
);
  cfg_cmd_t cmd;
  assign cmd = '{req: cfg_req_i, we: cfg_we_i, dw: cfg_dw_i, be: cfg_be_i, wdata: cfg_wdata_i};

  logic                       wr_en, rd_en;
  logic [NUM_BARS-1:0]        bar_sel;
  logic [NUM_BARS-1:0][31:0]  bars;
  logic [31:0]                rom_bar_q;
  logic [31:0]                rd_mux;
  logic [31:0]                rdata_q;

  assign wr_en = cmd.req &&  cmd.we;
  assign rd_en = cmd.req && !cmd.we;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_sel
    assign bar_sel[g] = (cmd.dw == 6'(DW_BAR0 + 6'(g)));
  end

  pci_cfg_bar_store #(.NUM(NUM_BARS)) u_bars (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bar_sel),
    .wr_i    (wr_en),
    .be_i    (cmd.be),
    .wdata_i (cmd.wdata),
    .bars_o  (bars)
  );

  pci_cfg_rom_bar #(.ROM_BYTES(ROM_BYTES)) u_rom_bar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en && (cmd.dw == DW_ROMBAR)),
    .be_i    (cmd.be),
    .wdata_i (cmd.wdata),
    .bar_o   (rom_bar_q)
  );

  pci_cfg_rom_decode #(
    .ROM_BYTES  (ROM_BYTES),
    .MEM_OFFSET (MEM_OFFSET),
    .MEM_LIMIT  (MEM_LIMIT)
  ) u_rom_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bar_i   (rom_bar_q),
    .req_i   (mem_req_i),
    .we_i    (mem_we_i),
    .addr_i  (mem_addr_i),
    .hit_o   (mem_hit_o),
    .rdata_o (mem_rdata_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (cmd.dw)
      DW_ID:     rd_mux = {DEVICE_ID, VENDOR_ID};
      DW_CLASS:  rd_mux = {CLASS_CODE, REVISION};
      DW_MISC:   rd_mux = {BIST, HDR_TYPE, LAT_TIMER, 8'h00};
      DW_SUBSYS: rd_mux = {SUBSYS_ID, SUBVEN_ID};
      DW_ROMBAR: rd_mux = rom_bar_q;
      DW_CAP:    rd_mux = 32'h0;
      default: begin
        for (int i = 0; i < NUM_BARS; i++)
          if (bar_sel[i]) rd_mux = bars[i];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_mux;
  end
  assign cfg_rdata_o = rdata_q;
endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk #(
  parameter int unsigned ROM_BYTES = 4096,
  parameter logic [31:0] MEM_LIMIT = 32'hC000_07FF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_i,
  input logic        mem_we_i,
  input logic [31:0] mem_addr_i,
  input logic        mem_hit_o,
  input logic [31:0] mem_rdata_o,
  input logic [31:0] rom_bar_i
);
  localparam logic [31:0] LOW_CLEAR = (ROM_BYTES == 0) ? 32'hFFFF_FFFF
                                    : ((32'(ROM_BYTES) - 32'd1) | 32'h0000_07FF) & ~32'd1;
  localparam logic [31:0] ZERO_CHK  = (ROM_BYTES == 0) ? 32'hFFFF_FFFF : LOW_CLEAR;

  AST_WRITE_NOT_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_i |=> !mem_hit_o); // R11
  AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !rom_bar_i[0] |=> !mem_hit_o); // R9
  AST_ABOVE_LIMIT_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && (mem_addr_i > MEM_LIMIT) |=> !mem_hit_o); // R10
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_i |=> !mem_hit_o); // R12
  AST_MISS_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_hit_o |-> (mem_rdata_o == 32'd0)); // R12
  AST_ROMBAR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_bar_i & ZERO_CHK) == 32'd0); // R6 R7
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(
  .ROM_BYTES (ROM_BYTES),
  .MEM_LIMIT (MEM_LIMIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_i   (mem_req_i),
  .mem_we_i    (mem_we_i),
  .mem_addr_i  (mem_addr_i),
  .mem_hit_o   (mem_hit_o),
  .mem_rdata_o (mem_rdata_o),
  .rom_bar_i   (rom_bar_q)
);

// File: tb/pci_cfg_hdr_bench.sv
module pci_cfg_hdr_bench;
  localparam logic [31:0] OFFS  = 32'h4000_0000;
  localparam logic [31:0] LIMIT = 32'hC000_07FF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [31:0] rd_main, rd_norom, rd_small, mr_main, mr_norom, mr_small;
  logic        mh_main, mh_norom, mh_small;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_cfg_hdr #(.ROM_BYTES(4096), .MEM_OFFSET(OFFS), .MEM_LIMIT(LIMIT)) u_pci_cfg_hdr (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_dw_i(cfg_dw),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_main), .mem_req_i(mem_req),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_hit_o(mh_main), .mem_rdata_o(mr_main));

  pci_cfg_hdr #(.ROM_BYTES(0), .MEM_OFFSET(OFFS), .MEM_LIMIT(LIMIT)) u_norom (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_dw_i(cfg_dw),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_norom), .mem_req_i(mem_req),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_hit_o(mh_norom), .mem_rdata_o(mr_norom));

  pci_cfg_hdr #(.ROM_BYTES(512), .MEM_OFFSET(OFFS), .MEM_LIMIT(LIMIT)) u_small (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_dw_i(cfg_dw),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd_small), .mem_req_i(mem_req),
    .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_hit_o(mh_small), .mem_rdata_o(mr_small));

  // {we, dw, be, wdata, expected read}
  typedef logic [1+6+4+32+32-1:0] vec_t;
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    {1'b0, 6'h00, 4'hF, 32'h0,          32'h0C3F_1AB7},  // R2
    {1'b0, 6'h02, 4'hF, 32'h0,          32'h0300_0003},  // R2
    {1'b0, 6'h03, 4'hF, 32'h0,          32'h0500_2000},  // R2
    {1'b1, 6'h03, 4'hF, 32'hFFFF_FFFF,  32'h0},
    {1'b0, 6'h03, 4'hF, 32'h0,          32'h0500_2000},  // R2 write ignored
    {1'b1, 6'h00, 4'hF, 32'h1234_5678,  32'h0},
    {1'b0, 6'h00, 4'hF, 32'h0,          32'h0C3F_1AB7},  // R2
    {1'b0, 6'h0B, 4'hF, 32'h0,          32'h7E02_2B11},  // R3
    {1'b1, 6'h0B, 4'hF, 32'h0000_0000,  32'h0},
    {1'b0, 6'h0B, 4'hF, 32'h0,          32'h7E02_2B11},  // R3
    {1'b0, 6'h0D, 4'hF, 32'h0,          32'h0},          // R4
    {1'b1, 6'h0D, 4'hF, 32'hFFFF_FFFF,  32'h0},
    {1'b0, 6'h0D, 4'hF, 32'h0,          32'h0},          // R4
    {1'b1, 6'h0F, 4'hF, 32'hA5A5_A5A5,  32'h0},
    {1'b0, 6'h0F, 4'hF, 32'h0,          32'h0},          // R4
    {1'b1, 6'h04, 4'hF, 32'h1234_5678,  32'h0},
    {1'b0, 6'h04, 4'hF, 32'h0,          32'h1234_5678},  // R5
    {1'b1, 6'h04, 4'h2, 32'hAABB_CCDD,  32'h0},
    {1'b0, 6'h04, 4'hF, 32'h0,          32'h1234_CC78},  // R5
    {1'b1, 6'h09, 4'hF, 32'hDEAD_BEEF,  32'h0},
    {1'b0, 6'h09, 4'hF, 32'h0,          32'hDEAD_BEEF},  // R5
    {1'b1, 6'h0C, 4'hF, 32'hFFFF_FFFF,  32'h0},
    {1'b0, 6'h0C, 4'hF, 32'h0,          32'hFFFF_F001},  // R6
    {1'b1, 6'h0C, 4'h1, 32'h0000_0000,  32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cfg_acc(input logic we, input logic [5:0] dw, input logic [3:0] be,
                         input logic [31:0] wd);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_dw = dw; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic mem_acc(input logic we, input logic [31:0] a);
    @(negedge clk);
    mem_req = 1'b1; mem_we = we; mem_addr = a;
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] k);
    return k[31:24] ^ k[23:16] ^ k[15:8] ^ k[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] o);
    logic [31:0] b;
    b = {o[31:2], 2'b00};
    return {exp_byte(b + 3), exp_byte(b + 2), exp_byte(b + 1), exp_byte(b)};
  endfunction

  task automatic rom_read(input string req, input logic [31:0] a, input logic exp_hit,
                          input logic [31:0] win_start);
    mem_acc(1'b0, a);
    chk({req, " hit"}, {31'd0, mh_main}, {31'd0, exp_hit});
    chk({req, " data"}, mr_main, exp_hit ? exp_word(a - win_start) : 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg_rdata", rd_main, 32'h0);
    chk("R1 mem_hit", {31'd0, mh_main}, 32'h0);
    chk("R1 mem_rdata", mr_main, 32'h0);
    rst_ni = 1'b1;
    cfg_acc(1'b0, 6'h0C, 4'hF, 32'h0);
    chk("R1 rom bar", rd_main, 32'h0);
    rom_read("R1 rom disabled", OFFS, 1'b0, OFFS);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      cfg_acc(v[74], v[73:68], v[67:64], v[63:32]);
      if (!v[74]) chk("R2-5 table R8", rd_main, v[31:0]);
    end
    cfg_acc(1'b0, 6'h0C, 4'hF, 32'h0);
    chk("R6 byte-enable clears enable", rd_main, 32'hFFFF_F000);

    // R8: read data held while no read is issued
    cfg_acc(1'b1, 6'h05, 4'hF, 32'h0BAD_F00D);
    chk("R8 hold over write", rd_main, 32'hFFFF_F000);
    cfg_acc(1'b0, 6'h05, 4'hF, 32'h0);
    chk("R8 write visible", rd_main, 32'h0BAD_F00D);

    // R7 no ROM, R6 2 KB floor
    cfg_acc(1'b1, 6'h0C, 4'hF, 32'hFFFF_FFFF);
    cfg_acc(1'b0, 6'h0C, 4'hF, 32'h0);
    chk("R7 no-rom probe", rd_norom, 32'h0);
    chk("R6 small rom floor", rd_small, 32'hFFFF_F801);
    chk("R6 size mask", rd_main, 32'hFFFF_F001);

    // R9 window decode
    cfg_acc(1'b1, 6'h0C, 4'hF, 32'h0000_2001);
    rom_read("R9 R12 first dword", OFFS + 32'h2000, 1'b1, OFFS + 32'h2000);
    rom_read("R12 unaligned", OFFS + 32'h2006, 1'b1, OFFS + 32'h2000);
    rom_read("R9 R12 last dword", OFFS + 32'h2FFE, 1'b1, OFFS + 32'h2000);
    rom_read("R9 above window", OFFS + 32'h3000, 1'b0, OFFS + 32'h2000);
    rom_read("R9 below window", OFFS + 32'h1FFC, 1'b0, OFFS + 32'h2000);
    rom_read("R9 no offset", 32'h0000_2000, 1'b0, OFFS + 32'h2000);
    mem_acc(1'b0, OFFS);
    chk("R7 no-rom miss", {31'd0, mh_norom}, 32'h0);
    // R11 writes not claimed
    mem_acc(1'b1, OFFS + 32'h2000);
    chk("R11 write hit", {31'd0, mh_main}, 32'h0);
    chk("R11 write data", mr_main, 32'h0);
    // R9 disable
    cfg_acc(1'b1, 6'h0C, 4'h1, 32'h0000_0000);
    rom_read("R9 disabled", OFFS + 32'h2000, 1'b0, OFFS + 32'h2000);
    // R10 clamp
    cfg_acc(1'b1, 6'h0C, 4'hF, 32'h8000_0001);
    rom_read("R10 below limit", 32'hC000_07FC, 1'b1, 32'hC000_0000);
    rom_read("R10 window start", 32'hC000_0000, 1'b1, 32'hC000_0000);
    rom_read("R10 above limit", 32'hC000_0800, 1'b0, 32'hC000_0000);
    rom_read("R10 window tail", 32'hC000_0FFC, 1'b0, 32'hC000_0000);

    // R1 reset again
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    cfg_acc(1'b0, 6'h0C, 4'hF, 32'h0);
    chk("R1 rom bar after reset", rd_main, 32'h0);
    cfg_acc(1'b0, 6'h04, 4'hF, 32'h0);
    chk("R1 bar after reset", rd_main, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule